// File: doc/BRIEF.md
# Masked Fault-Checking Montgomery Ladder Exponentiator

This block computes a modular exponentiation with a regular Montgomery ladder. The ladder hides which exponent bits are ones: every step uses two multiplier units in parallel, one forming the product of the two ladder values and one squaring either value. A third unit squares an inverse blinding value in the same steps. The message enters the ladder multiplied by a random factor b, and the third stream tracks b's inverse as the mask is squared, so one final multiplication removes the mask. A random additive term a, supplied in Montgomery form, is added to both results as they leave the Montgomery domain. This keeps the plain power off the outputs until a consumer that knows a removes it.

All arithmetic uses radix-2 bit-serial Montgomery multiplication with R = 2^(W+2). Each product takes W+2 rounds and is then reduced below N. The caller supplies four constants computed outside the block: b·R² mod N, R² mod N, b⁻¹·R mod N and a·R mod N. The modulus N must be odd, and b must be invertible mod N. The exponent is EXP_W bits wide, with its top bit set and its lowest bit set.

A protection stage keeps a shadow copy of the exponent and a separate step counter. When the run ends, it compares them with the working exponent and the loop index. Any difference ends the run in a fault state instead of the done state, and the data outputs stay at zero.

Top module: `masked_ladder_exp`

States: ST_IDLE, ST_INIT_A (mask the message and bring it to Montgomery form), ST_INIT_B (form the masked square), ST_LADDER (one step per exponent bit, from bit EXP_W-2 down to bit 1), ST_FINISH_A (implicit last step for bit 0, plus a final square of the inverse mask), ST_FINISH_B (remove the mask), ST_UNMASK (add a and leave the domain), ST_VERIFY, ST_DONE and ST_FAULT.

Transitions:
- From ST_IDLE, ST_DONE or ST_FAULT, a start moves to ST_INIT_A.
- Each arithmetic state advances when its products complete.
- ST_LADDER repeats until the step for bit 1 completes.
- ST_VERIFY goes to ST_DONE when the protection check passes, and to ST_FAULT otherwise.

## Requirements
- R1: After reset, busy, done and fault are 0 and res_lo and res_hi are 0.
- R2: start while the block is idle, done or faulted launches a run, and busy is 1 after that clock edge.
- R3: For an exponent e with bit EXP_W-1 and bit 0 set, and any W-bit message m, res_lo equals (a + m^(e-1)) mod N and res_hi equals (a + m^e) mod N. The inputs are blind_r2 = b·R² mod N, rsq = R² mod N, unblind = b⁻¹·R mod N and a_mont = a·R mod N, with R = 2^(W+2). Both results are below N.
- R4: done first reads 1 after the clock edge that comes (EXP_W+3)·(W+4)+1 edges after the edge that accepted start. busy is 1 from the accepting edge until that edge.
- R5: All operands are captured at the accepting edge. Input changes and start pulses during a run do not affect the results or the timing.
- R6: done and fault are never 1 together, and each holds until the next accepted start.
- R7: If the working exponent register differs from its shadow copy when the run ends, fault is 1 and done stays 0.
- R8: If the loop index is disturbed so that the number of ladder steps is not EXP_W-2, fault is 1 and done stays 0.
- R9: res_lo and res_hi are 0 whenever done is 0, including in the fault state.
- R10: For the same m, e, a and N, the results do not depend on the blinding factor b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, taken when not busy |
| msg | input | W | Message m |
| modulus | input | W | Odd modulus N |
| blind_r2 | input | W | b·R² mod N |
| rsq | input | W | R² mod N |
| unblind | input | W | b⁻¹·R mod N |
| a_mont | input | W | a·R mod N |
| exponent | input | EXP_W | Exponent e, top bit and bit 0 set |
| busy | output | 1 | Run in progress |
| done | output | 1 | Results valid |
| fault | output | 1 | Tampering detected |
| res_lo | output | W | (a + m^(e-1)) mod N |
| res_hi | output | W | (a + m^e) mod N |

## Verification
The assertions check on every cycle that done and fault exclude each other and persist, that the results are zero outside the done state and reduced below the captured modulus in it, and that an accepted start raises busy. The arithmetic can only be shown by the bench's scenarios. These cover the blinding with different b values, the ladder paths for different exponent bit patterns, messages of zero, one, N-1 and above N, and the exact completion cycle. The tamper paths are also shown there, by forcing the working exponent or the loop index during a run.

// File: rtl/mlx_pkg.sv
package mlx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_INIT_A,
        ST_INIT_B,
        ST_LADDER,
        ST_FINISH_A,
        ST_FINISH_B,
        ST_UNMASK,
        ST_VERIFY,
        ST_DONE,
        ST_FAULT
    } ladder_state_e;

    // unit 0: cross product, unit 1: ladder squarer, unit 2: mask squarer
    localparam int NUM_UNITS = 3;

endpackage

// File: rtl/mont_mul_serial.sv
module mont_mul_serial #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W:0]   op_x,
    input  logic [W:0]   op_y,
    input  logic [W-1:0] modulus,
    output logic         done,
    output logic [W-1:0] product
);
    localparam int ROUNDS = W + 2;
    localparam int AW     = W + 3;
    localparam int CW     = $clog2(ROUNDS + 1);
    localparam logic [CW-1:0] LAST = CW'(ROUNDS - 1);

    logic [W+1:0]  xs;
    logic [AW-1:0] acc, ys, nn, sum, diff, red;
    logic [CW-1:0] cnt;
    logic          busy, qbit;
    logic          unused_hi;

    always_comb begin
        qbit      = acc[0] ^ (xs[0] & ys[0]);
        sum       = acc + (xs[0] ? ys : '0) + (qbit ? nn : '0);
        diff      = acc - nn;
        red       = (acc >= nn) ? diff : acc;
        product   = red[W-1:0];
        unused_hi = ^red[AW-1:W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            acc  <= '0;
            xs   <= '0;
            ys   <= '0;
            nn   <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy <= 1'b1;
                cnt  <= '0;
                acc  <= '0;
                xs   <= {1'b0, op_x};
                ys   <= {2'b0, op_y};
                nn   <= {3'b0, modulus};
            end else if (busy) begin
                acc <= sum >> 1;
                xs  <= xs >> 1;
                cnt <= cnt + 1'b1;
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ladder_guard.sv
module ladder_guard #(
    parameter int EXP_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     arm,
    input  logic [EXP_W-1:0]         exp_in,
    input  logic                     step,
    input  logic [EXP_W-1:0]         exp_work,
    input  logic [$clog2(EXP_W)-1:0] loop_idx,
    output logic                     tamper
);
    localparam int IW = $clog2(EXP_W);
    localparam logic [IW-1:0] STEPS = IW'(EXP_W - 2);

    logic [EXP_W-1:0] shadow;
    logic [IW-1:0]    steps_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow     <= '0;
            steps_seen <= '0;
        end else if (arm) begin
            shadow     <= exp_in;
            steps_seen <= '0;
        end else if (step) begin
            steps_seen <= steps_seen + 1'b1;
        end
    end

    always_comb begin
        tamper = (shadow != exp_work) || (steps_seen != STEPS) || (loop_idx != '0);
    end

endmodule

// File: rtl/masked_ladder_exp.sv
module masked_ladder_exp
    import mlx_pkg::*;
#(
    parameter int W     = 16,
    parameter int EXP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     msg,
    input  logic [W-1:0]     modulus,
    input  logic [W-1:0]     blind_r2,
    input  logic [W-1:0]     rsq,
    input  logic [W-1:0]     unblind,
    input  logic [W-1:0]     a_mont,
    input  logic [EXP_W-1:0] exponent,
    output logic             busy,
    output logic             done,
    output logic             fault,
    output logic [W-1:0]     res_lo,
    output logic [W-1:0]     res_hi
);
    localparam int IW = $clog2(EXP_W);
    localparam logic [IW-1:0] IDX_FIRST = IW'(EXP_W - 2);
    localparam logic [IW-1:0] IDX_LAST  = IW'(1);
    localparam logic [W:0]    ONE       = (W+1)'(1);

    ladder_state_e state, state_nx;

    logic [W-1:0]     n_q, m_q, br_q, rsq_q, ar_q;
    logic [W-1:0]     s0, s1, s2;
    logic [EXP_W-1:0] exp_work;
    logic [IW-1:0]    loop_idx;
    logic             issued, accept, phase_st, unit_go, ph_done, lbit, tamper;
    logic             unused_done;

    logic [W:0]       ux    [NUM_UNITS];
    logic [W:0]       uy    [NUM_UNITS];
    logic [W-1:0]     uprod [NUM_UNITS];
    logic [NUM_UNITS-1:0] udone;

    always_comb begin
        busy     = !(state inside {ST_IDLE, ST_DONE, ST_FAULT});
        accept   = start && !busy;
        phase_st = state inside {ST_INIT_A, ST_INIT_B, ST_LADDER,
                                 ST_FINISH_A, ST_FINISH_B, ST_UNMASK};
        unit_go  = phase_st && !issued;
        ph_done  = udone[0];
        lbit     = exp_work[loop_idx];
        unused_done = udone[1] ^ udone[2];
    end

    // operand selection per phase
    always_comb begin
        for (int u = 0; u < NUM_UNITS; u++) begin
            ux[u] = '0;
            uy[u] = '0;
        end
        unique case (state)
            ST_INIT_A: begin
                ux[0] = {1'b0, m_q};  uy[0] = {1'b0, br_q};
                ux[1] = {1'b0, m_q};  uy[1] = {1'b0, rsq_q};
            end
            ST_INIT_B: begin
                ux[0] = {1'b0, s0};   uy[0] = {1'b0, s1};
            end
            ST_LADDER, ST_FINISH_A: begin
                ux[0] = {1'b0, s0};   uy[0] = {1'b0, s1};
                if (state == ST_LADDER && lbit) begin
                    ux[1] = {1'b0, s1}; uy[1] = {1'b0, s1};
                end else begin
                    ux[1] = {1'b0, s0}; uy[1] = {1'b0, s0};
                end
                ux[2] = {1'b0, s2};   uy[2] = {1'b0, s2};
            end
            ST_FINISH_B: begin
                ux[0] = {1'b0, s1};   uy[0] = {1'b0, s2};
                ux[1] = {1'b0, s0};   uy[1] = {1'b0, s2};
            end
            ST_UNMASK: begin
                ux[0] = {1'b0, s1} + {1'b0, ar_q};  uy[0] = ONE;
                ux[1] = {1'b0, s0} + {1'b0, ar_q};  uy[1] = ONE;
            end
            default: ;
        endcase
    end

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
        mont_mul_serial #(.W(W)) u_mm (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (unit_go),
            .op_x    (ux[g]),
            .op_y    (uy[g]),
            .modulus (n_q),
            .done    (udone[g]),
            .product (uprod[g])
        );
    end

    ladder_guard #(.EXP_W(EXP_W)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (accept),
        .exp_in   (exponent),
        .step     (state == ST_LADDER && ph_done),
        .exp_work (exp_work),
        .loop_idx (loop_idx),
        .tamper   (tamper)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_DONE, ST_FAULT: if (start) state_nx = ST_INIT_A;
            ST_INIT_A:   if (ph_done) state_nx = ST_INIT_B;
            ST_INIT_B:   if (ph_done) state_nx = ST_LADDER;
            ST_LADDER:   if (ph_done && loop_idx == IDX_LAST) state_nx = ST_FINISH_A;
            ST_FINISH_A: if (ph_done) state_nx = ST_FINISH_B;
            ST_FINISH_B: if (ph_done) state_nx = ST_UNMASK;
            ST_UNMASK:   if (ph_done) state_nx = ST_VERIFY;
            ST_VERIFY:   state_nx = tamper ? ST_FAULT : ST_DONE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q <= '0; m_q <= '0; br_q <= '0; rsq_q <= '0; ar_q <= '0;
            s0 <= '0; s1 <= '0; s2 <= '0;
            exp_work <= '0; loop_idx <= '0; issued <= 1'b0;
        end else if (accept) begin
            n_q      <= modulus;
            m_q      <= msg;
            br_q     <= blind_r2;
            rsq_q    <= rsq;
            ar_q     <= a_mont;
            s2       <= unblind;
            exp_work <= exponent;
            loop_idx <= IDX_FIRST;
            issued   <= 1'b0;
        end else begin
            if (unit_go) issued <= 1'b1;
            if (ph_done) begin
                issued <= 1'b0;
                unique case (state)
                    ST_INIT_A: begin s0 <= uprod[0]; s1 <= uprod[1]; end
                    ST_INIT_B: s1 <= uprod[0];
                    ST_LADDER: begin
                        if (lbit) begin s0 <= uprod[0]; s1 <= uprod[1]; end
                        else      begin s1 <= uprod[0]; s0 <= uprod[1]; end
                        s2       <= uprod[2];
                        loop_idx <= loop_idx - 1'b1;
                    end
                    ST_FINISH_A: begin s1 <= uprod[0]; s0 <= uprod[1]; s2 <= uprod[2]; end
                    ST_FINISH_B, ST_UNMASK: begin s1 <= uprod[0]; s0 <= uprod[1]; end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        done   = (state == ST_DONE);
        fault  = (state == ST_FAULT);
        res_lo = done ? s0 : '0;
        res_hi = done ? s1 : '0;
    end

endmodule

// File: rtl/mlx_checker.sv
module mlx_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic         fault,
    input logic [W-1:0] res_lo,
    input logic [W-1:0] res_hi,
    input logic [W-1:0] n_q
);
    p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_fault_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !start) |=> fault);

    p_zero_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (res_lo == '0 && res_hi == '0));

    p_reduced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (res_lo < n_q && res_hi < n_q));

    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

bind masked_ladder_exp mlx_checker #(.W(W)) u_mlx_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .fault  (fault),
    .res_lo (res_lo),
    .res_hi (res_hi),
    .n_q    (n_q)
);

// File: tb/test_masked_ladder_exp.sv
module test_masked_ladder_exp;
    localparam int W          = 16;
    localparam int EXP_W      = 8;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_LEN    = (EXP_W + 3) * (W + 4) + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [W-1:0]     msg = '0, modulus = '0, blind_r2 = '0, rsq = '0, unblind = '0, a_mont = '0;
    logic [EXP_W-1:0] exponent = '0;
    logic             busy, done, fault;
    logic [W-1:0]     res_lo, res_hi;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    masked_ladder_exp #(.W(W), .EXP_W(EXP_W)) i_masked_ladder_exp (
        .clk(clk), .rst_n(rst_n), .start(start), .msg(msg), .modulus(modulus),
        .blind_r2(blind_r2), .rsq(rsq), .unblind(unblind), .a_mont(a_mont),
        .exponent(exponent), .busy(busy), .done(done), .fault(fault),
        .res_lo(res_lo), .res_hi(res_hi)
    );

    function automatic longint powmod(longint base, longint ex, longint n);
        longint r = 1;
        base = base % n;
        while (ex > 0) begin
            if (ex % 2 == 1) r = (r * base) % n;
            base = (base * base) % n;
            ex = ex / 2;
        end
        return r;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // behavioural reference: run length counter and expected pair
    bit     m_busy, m_done, m_fault, m_fault_mode, pend_fault;
    int     m_left;
    longint m_lo, m_hi, pend_lo, pend_hi;
    bit     cmp_en = 1'b1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_fault = 0; m_left = 0;
        end else if (!m_busy && start) begin
            m_busy = 1; m_done = 0; m_fault = 0; m_left = RUN_LEN;
            m_lo = pend_lo; m_hi = pend_hi; m_fault_mode = pend_fault;
        end else if (m_busy) begin
            m_left--;
            if (m_left == 0) begin
                m_busy = 0;
                if (m_fault_mode) m_fault = 1; else m_done = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk("R4", "busy", busy, m_busy);
            chk("R4", "done", done, m_done);
            chk("R7", "fault", fault, m_fault);
            if (m_done) begin
                chk("R3", "res_lo", res_lo, m_lo);
                chk("R3", "res_hi", res_hi, m_hi);
            end else begin
                chk("R9", "res_lo zero", res_lo, 0);
                chk("R9", "res_hi zero", res_hi, 0);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    // drive operands at a falling edge and pulse start for one cycle
    task automatic launch(longint n, longint m, longint e, longint a, longint b, bit flt);
        longint rm, binv;
        rm   = (longint'(1) << (W + 2)) % n;
        binv = powmod(b, n - 2, n);
        modulus  = W'(n);
        msg      = W'(m);
        exponent = EXP_W'(e);
        blind_r2 = W'((b * ((rm * rm) % n)) % n);
        rsq      = W'((rm * rm) % n);
        unblind  = W'((binv * rm) % n);
        a_mont   = W'((a * rm) % n);
        pend_lo  = (a + powmod(m, e - 1, n)) % n;
        pend_hi  = (a + powmod(m, e, n)) % n;
        pend_fault = flt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_vec(string tag, longint n, longint m, longint e, longint a, longint b,
                           output longint lo, output longint hi);
        launch(n, m, e, a, b, 1'b0);
        repeat (RUN_LEN + 1) @(negedge clk);
        chk(tag, "done at end", done, 1);
        chk(tag, "res_lo", res_lo, (a + powmod(m, e - 1, n)) % n);
        chk(tag, "res_hi", res_hi, (a + powmod(m, e, n)) % n);
        lo = res_lo;
        hi = res_hi;
    endtask

    initial begin
        longint lo1, hi1, lo2, hi2;
        repeat (3) @(negedge clk);
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "done after reset", done, 0);
        chk("R1", "fault after reset", fault, 0);
        chk("R1", "res_lo after reset", res_lo, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4: main function over several bit patterns and messages
        launch(65521, 12345, 'hB5, 777, 4242, 1'b0);
        chk("R2", "busy after launch", busy, 1);
        repeat (RUN_LEN) @(negedge clk);
        chk("R3", "res_lo m=12345", res_lo, (777 + powmod(12345, 'hB4, 65521)) % 65521);
        chk("R3", "res_hi m=12345", res_hi, (777 + powmod(12345, 'hB5, 65521)) % 65521);
        run_vec("R3", 65521, 0, 'h81, 100, 9, lo1, hi1);
        run_vec("R3", 65521, 1, 'hFF, 65520, 31, lo1, hi1);
        run_vec("R3", 65521, 65520, 'hC3, 5, 1000, lo1, hi1);
        run_vec("R3", 32749, 40000, 'h9F, 12, 77, lo1, hi1);
        run_vec("R3", 257, 200, 'hAB, 256, 3, lo1, hi1);
        run_vec("R3", 251, 250, 'hD5, 0, 250, lo1, hi1);

        // R10: same operands with two blinding factors
        run_vec("R10", 65521, 4321, 'hE7, 99, 2, lo1, hi1);
        run_vec("R10", 65521, 4321, 'hE7, 99, 60000, lo2, hi2);
        chk("R10", "res_lo across b", lo2, lo1);
        chk("R10", "res_hi across b", hi2, hi1);

        // R5: operand changes and a start pulse mid-run are ignored
        launch(32749, 1234, 'hB3, 42, 17, 1'b0);
        repeat (40) @(negedge clk);
        msg = 16'h0F0F; modulus = 16'h1235; exponent = 8'h81; a_mont = 16'h0001;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (RUN_LEN - 41) @(negedge clk);
        chk("R5", "res_lo unchanged", res_lo, (42 + powmod(1234, 'hB2, 32749)) % 32749);
        chk("R5", "res_hi unchanged", res_hi, (42 + powmod(1234, 'hB3, 32749)) % 32749);
        repeat (5) @(negedge clk);
        chk("R6", "done held", done, 1);

        // R7: working exponent disturbed mid-run
        launch(65521, 321, 'hA5, 7, 11, 1'b1);
        repeat (60) @(negedge clk);
        force i_masked_ladder_exp.exp_work = 8'hA5 ^ 8'h08;
        @(negedge clk);
        release i_masked_ladder_exp.exp_work;
        repeat (RUN_LEN) @(negedge clk);
        chk("R7", "fault raised", fault, 1);
        chk("R7", "done low on fault", done, 0);
        chk("R9", "res_hi zero on fault", res_hi, 0);
        repeat (3) @(negedge clk);
        chk("R6", "fault held", fault, 1);

        // R6: a fresh run after a fault completes normally
        run_vec("R6", 257, 5, 'h93, 1, 2, lo1, hi1);

        // R8: loop index disturbed, run ends early with a fault
        cmp_en = 1'b0;
        launch(65521, 999, 'hF1, 3, 5, 1'b1);
        repeat (100) @(negedge clk);
        force i_masked_ladder_exp.loop_idx = 3'd1;
        @(negedge clk);
        release i_masked_ladder_exp.loop_idx;
        for (int k = 0; k < 400 && !(done || fault); k++) @(negedge clk);
        chk("R8", "fault on loop tamper", fault, 1);
        chk("R8", "done low on loop tamper", done, 0);
        chk("R8", "res_lo zero", res_lo, 0);

        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "fault cleared by reset", fault, 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1'b1;
        run_vec("R3", 32749, 3, 'hC7, 500, 12, lo1, hi1);

        summary();
        $finish;
    end

endmodule